// File: doc/BRIEF.md
# Single-Channel PWM Generator with Queued Duty Samples

This block drives one pulse-width-modulated output from a small register file. Software programs a prescale ratio, a period length and an output polarity in a control word. It then queues duty values into a four-deep sample queue through a write-only sample port. A free-running timebase counts prescaled clocks. The output stays asserted from the start of each period until the counter reaches the active duty value.

A new duty value is taken from the queue only at a period boundary. A value is also taken at the moment the generator is switched on. This lets software keep a few periods of duty values in flight without glitches. A status word reports how full the queue is. A self-clearing soft reset returns the whole block to idle: it empties the queue, clears the period and the active duty value, and clears the control word.

Some control fields have no effect in this block: a two-bit clock-source selector and four low-power run-enable flags. They are stored so that software reads back what it wrote.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After the synchronous reset, the control word at offset 0x00 reads 0, the status word at offset 0x04 reads 0, and `pwm_o` is 0.
- R2: With control bit 0 set, the output pattern repeats every (prescale + 1) * (period + 2) clocks, where period is the value written at offset 0x10.
- R3: Control bits [15:4] hold the prescale field; one timebase step lasts (field + 1) clocks.
- R4: With polarity not inverted, `pwm_o` is high for the first duty * (prescale + 1) clocks of each period, where duty is the active sample written at offset 0x0C. A duty of 0 gives a constant low output. A duty of period + 2 or more gives a constant high output.
- R5: Samples queue in write order, up to 4 deep, and status bits [2:0] give the number queued. One sample is taken when the generator is enabled and one at each period end. If the queue is empty, the previous duty is kept.
- R6: A sample written while 4 samples are queued is dropped, and the queue contents do not change.
- R7: Writing control with bit 3 set starts a soft reset. Bit 3 then reads 1 for 4 clocks and then clears. The soft reset clears the control word, the period, the active duty and the queue, and register writes are ignored while it runs.
- R8: Control bit 18 inverts the output.
- R9: While control bit 0 is 0, the timebase is held at 0 and `pwm_o` sits at its inactive level: 0, or 1 when bit 18 is set. Writing control with bit 0 clear stops a running output.
- R10: Control bits [17:16] and [25:22] are stored and read back but do not change the output. All other unlisted control bits read 0.
- R11: A sample write in the same clock as a period-end take leaves the queue level unchanged, and both operations take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_o | output | 1 | Registered PWM output |

## Verification
Two functions can fall in the same clock: a sample write from the bus, and the queue take at a period rollover. The bench counts edges from the enabling write to find the rollover edge, and places a sample write on exactly that edge. It then judges the outcome in two ways: the status level read right afterwards must be unchanged, and the duty sequence seen on `pwm_o` over the following periods must include both the taken sample and the new one, in order. A second pairing checks that a write to a full queue is dropped, by looking at which duties appear on the output afterwards.

// File: rtl/pwm_fifo_pkg.sv
`timescale 1ns/1ps
package pwm_fifo_pkg;
  // register offsets (byte addresses)
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_STATUS = 'h04;
  localparam int OFS_SAMPLE = 'h0C;
  localparam int OFS_PERIOD = 'h10;

  // control word field positions
  localparam int CB_RUN     = 0;
  localparam int CB_SRST    = 3;
  localparam int CB_DIV_LO  = 4;
  localparam int DIV_W      = 12;
  localparam int CB_SRC_LO  = 16;
  localparam int CB_INV     = 18;
  localparam int CB_LP_LO   = 22;
endpackage

// File: rtl/pwm_sample_fifo.sv
`timescale 1ns/1ps
module pwm_sample_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign push_ok = push && (level != LVL_FULL);
  assign pop_ok  = pop && (level != '0);
  assign head    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
  parameter int DIV_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W:0]   cnt,
  output logic             wrap
);
  logic [DIV_W-1:0] pre;
  logic [CNT_W:0]   last;
  logic             tick;

  assign last = {1'b0, period} + (CNT_W+1)'(1);
  assign tick = (pre >= div);
  assign wrap = run && tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_compare_out.sv
`timescale 1ns/1ps
module pwm_compare_out #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             inv,
  input  logic [CNT_W:0]   cnt,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_o
);
  logic active_phase;
  assign active_phase = (cnt < {1'b0, duty});

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= run ? (active_phase ^ inv) : inv;
  end
endmodule

// File: rtl/pwm_fifo_gen.sv
`timescale 1ns/1ps
module pwm_fifo_gen
  import pwm_fifo_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int SRST_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_o
);
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
  localparam int SRST_W = (SRST_CYC > 1) ? $clog2(SRST_CYC) : 1;

  // control state
  logic             en_q, inv_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       src_q;
  logic [3:0]       lp_q;
  logic [CNT_W-1:0] period_q, active_q;
  logic             srst_busy;
  logic [SRST_W-1:0] srst_cnt;

  // decode
  logic sel_ctrl, sel_stat, sel_samp, sel_per;
  logic wr_ctrl, srst_req, wr_ctrl_cfg, wr_samp, wr_per, en_rise;
  logic pop;
  logic [CNT_W-1:0] fifo_head;
  logic [LVL_W-1:0] level;
  logic [CNT_W:0]   cnt;
  logic             wrap;
  logic [DATA_W-1:0] ctrl_view, rd_mux;
  logic             unused_wbits;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STATUS));
  assign sel_samp = (bus_addr == ADDR_W'(OFS_SAMPLE));
  assign sel_per  = (bus_addr == ADDR_W'(OFS_PERIOD));

  assign wr_ctrl     = bus_wr && sel_ctrl && !srst_busy;
  assign srst_req    = wr_ctrl && bus_wdata[CB_SRST];
  assign wr_ctrl_cfg = wr_ctrl && !bus_wdata[CB_SRST];
  assign wr_samp     = bus_wr && sel_samp && !srst_busy;
  assign wr_per      = bus_wr && sel_per && !srst_busy;
  assign en_rise     = wr_ctrl_cfg && bus_wdata[CB_RUN] && !en_q;
  assign pop         = (level != '0) && (en_rise || wrap);

  assign unused_wbits = ^{bus_wdata[2:1], bus_wdata[21:19], bus_wdata[DATA_W-1:26]};

  // control and period registers; soft reset clears them
  always_ff @(posedge clk) begin
    if (rst || srst_req) begin
      en_q     <= 1'b0;
      inv_q    <= 1'b0;
      div_q    <= '0;
      src_q    <= '0;
      lp_q     <= '0;
      period_q <= '0;
    end else begin
      if (wr_ctrl_cfg) begin
        en_q  <= bus_wdata[CB_RUN];
        inv_q <= bus_wdata[CB_INV];
        div_q <= bus_wdata[CB_DIV_LO +: DIV_W];
        src_q <= bus_wdata[CB_SRC_LO +: 2];
        lp_q  <= bus_wdata[CB_LP_LO +: 4];
      end
      if (wr_per) period_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // active duty value, refreshed on each take from the queue
  always_ff @(posedge clk) begin
    if (rst || srst_req) active_q <= '0;
    else if (pop)        active_q <= fifo_head;
  end

  // self-clearing soft reset sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      srst_busy <= 1'b0;
      srst_cnt  <= '0;
    end else if (srst_req) begin
      srst_busy <= 1'b1;
      srst_cnt  <= SRST_W'(SRST_CYC - 1);
    end else if (srst_busy) begin
      if (srst_cnt == '0) srst_busy <= 1'b0;
      else                srst_cnt  <= srst_cnt - 1'b1;
    end
  end

  // read path
  always_comb begin
    ctrl_view = '0;
    ctrl_view[CB_RUN]              = en_q;
    ctrl_view[CB_SRST]             = srst_busy;
    ctrl_view[CB_DIV_LO +: DIV_W]  = div_q;
    ctrl_view[CB_SRC_LO +: 2]      = src_q;
    ctrl_view[CB_INV]              = inv_q;
    ctrl_view[CB_LP_LO +: 4]       = lp_q;
    if (sel_ctrl)      rd_mux = ctrl_view;
    else if (sel_stat) rd_mux = DATA_W'(level);
    else if (sel_per)  rd_mux = DATA_W'(period_q);
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  pwm_sample_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) fifo_i (
    .clk(clk), .rst(rst), .clr(srst_req),
    .push(wr_samp), .push_data(bus_wdata[CNT_W-1:0]),
    .pop(pop), .head(fifo_head), .level(level)
  );

  pwm_timebase #(.DIV_W(DIV_W), .CNT_W(CNT_W)) tb_i (
    .clk(clk), .rst(rst), .run(en_q), .div(div_q), .period(period_q),
    .cnt(cnt), .wrap(wrap)
  );

  pwm_compare_out #(.CNT_W(CNT_W)) out_i (
    .clk(clk), .rst(rst), .run(en_q), .inv(inv_q), .cnt(cnt),
    .duty(active_q), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/pwm_fifo_gen_chk.sv
`timescale 1ns/1ps
module pwm_fifo_gen_chk
  import pwm_fifo_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wbit_srst,
  input logic              en_q,
  input logic              inv_q,
  input logic              srst_busy,
  input logic [LVL_W-1:0]  level,
  input logic              pop,
  input logic [CNT_W:0]    cnt,
  input logic [CNT_W-1:0]  active_q,
  input logic              pwm_o
);
  logic samp_wr;
  assign samp_wr = bus_wr && (bus_addr == ADDR_W'(OFS_SAMPLE)) && !srst_busy;

  // R5: queue level never exceeds its depth
  a_r5_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(FIFO_DEPTH));

  // R6: write into a full queue without a take keeps it full
  a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
    (samp_wr && level == LVL_W'(FIFO_DEPTH) && !pop) |=> level == LVL_W'(FIFO_DEPTH));

  // R11: push and take in one clock keep the level
  a_r11_push_pop: assert property (@(posedge clk) disable iff (rst)
    (samp_wr && pop && level != '0 && level != LVL_W'(FIFO_DEPTH)) |=> level == $past(level));

  // R7: soft reset empties the queue, stops the output and reports busy
  a_r7_srst_flush: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && wbit_srst && !srst_busy)
      |=> (level == '0 && srst_busy && !en_q));

  // R9: disabled for two clocks means idle timebase and inactive output
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    (!en_q && $past(!en_q)) |-> (cnt == '0 && pwm_o == $past(inv_q)));

  // R4: zero duty with normal polarity gives a low output
  a_r4_zero_low: assert property (@(posedge clk) disable iff (rst)
    $past(en_q && active_q == '0 && !inv_q) |-> !pwm_o);
endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wbit_srst(bus_wdata[3]), .en_q(en_q), .inv_q(inv_q),
  .srst_busy(srst_busy), .level(level), .pop(pop), .cnt(cnt),
  .active_q(active_q), .pwm_o(pwm_o)
);

// File: tb/pwm_fifo_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_fifo_gen_tb_top;
  localparam int SRST = 4;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SAMP = 5'h0C, A_PER = 5'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_fifo_gen dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  // Called right after the enabling write returns.
  task automatic check_wave(input string tag, input int d, input int p, input bit inv,
                            input int nper, input int act[8]);
    int len;
    len = d * (p + 2);
    for (int j = 1; j <= nper * len; j++) begin
      int k, per, c;
      logic e;
      @(negedge clk);
      k = j - 1;
      per = k / len;
      if (per > 7) per = 7;
      c = (k / d) % (p + 2);
      e = (c < act[per]) ^ inv;
      check(tag, {31'b0, pwm_o}, {31'b0, e});
    end
  endtask

  task automatic soft_reset();
    bus_write(A_CTRL, 32'h8);
    repeat (SRST + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 pwm after reset", {31'b0, pwm_o}, 32'h0);
    expect_reg("R1 ctrl after reset", A_CTRL, 32'h0);
    expect_reg("R1 status after reset", A_STAT, 32'h0);
  endtask

  task automatic t_basic();
    soft_reset();
    bus_write(A_PER, 6);
    bus_write(A_SAMP, 3);
    bus_write(A_CTRL, 32'h1);
    check_wave("R2 R4 basic wave", 1, 6, 0, 3, '{3,3,3,3,3,3,3,3});
    bus_write(A_CTRL, 32'h0);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check("R9 stopped output low", {31'b0, pwm_o}, 32'h0);
      @(negedge clk);
    end
  endtask

  task automatic t_prescale();
    soft_reset();
    bus_write(A_PER, 2);
    bus_write(A_SAMP, 2);
    bus_write(A_CTRL, (32'd2 << 4) | 32'h1);
    check_wave("R3 prescale by 3", 3, 2, 0, 3, '{2,2,2,2,2,2,2,2});
  endtask

  task automatic t_fifo_order();
    soft_reset();
    bus_write(A_PER, 4);
    bus_write(A_SAMP, 1);
    bus_write(A_SAMP, 4);
    bus_write(A_SAMP, 2);
    expect_reg("R5 level three", A_STAT, 32'd3);
    bus_write(A_CTRL, 32'h1);
    check_wave("R5 queue order", 1, 4, 0, 4, '{1,4,2,2,2,2,2,2});
    expect_reg("R5 level drained", A_STAT, 32'd0);
  endtask

  task automatic t_full_drop();
    soft_reset();
    bus_write(A_PER, 4);
    for (int i = 1; i <= 5; i++) bus_write(A_SAMP, i);
    expect_reg("R6 level full", A_STAT, 32'd4);
    bus_write(A_CTRL, 32'h1);
    check_wave("R6 dropped fifth", 1, 4, 0, 5, '{1,2,3,4,4,4,4,4});
  endtask

  task automatic t_collision();
    soft_reset();
    bus_write(A_PER, 4);
    bus_write(A_SAMP, 1);
    bus_write(A_SAMP, 3);
    bus_write(A_CTRL, 32'h1);   // enable edge E0 takes sample 1
    fork
      check_wave("R11 order after collision", 1, 4, 0, 5, '{1,3,5,2,2,2,2,2});
      begin
        bus_write(A_SAMP, 5);   // lands on E2
        repeat (2) @(negedge clk);
        bus_write(A_SAMP, 2);   // lands on E6, the first rollover
        expect_reg("R11 level kept", A_STAT, 32'd2);
      end
    join
  endtask

  task automatic t_soft_reset();
    soft_reset();
    bus_write(A_PER, 5);
    bus_write(A_SAMP, 7);
    bus_write(A_SAMP, 7);
    bus_write(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    bus_write(A_CTRL, 32'h8 | (32'h1 << 18) | 32'h1);
    expect_reg("R7 busy bit", A_CTRL, 32'h8);
    bus_write(A_PER, 9);        // must be ignored while busy
    repeat (SRST + 2) @(negedge clk);
    expect_reg("R7 ctrl cleared", A_CTRL, 32'h0);
    expect_reg("R7 period cleared", A_PER, 32'h0);
    expect_reg("R7 queue flushed", A_STAT, 32'h0);
    check("R7 output idle", {31'b0, pwm_o}, 32'h0);
  endtask

  task automatic t_invert();
    soft_reset();
    bus_write(A_PER, 4);
    bus_write(A_SAMP, 2);
    bus_write(A_CTRL, 32'h1 << 18);
    @(negedge clk);
    check("R9 inactive high when inverted", {31'b0, pwm_o}, 32'h1);
    bus_write(A_CTRL, (32'h1 << 18) | 32'h1);
    check_wave("R8 inverted wave", 1, 4, 1, 3, '{2,2,2,2,2,2,2,2});
    bus_write(A_CTRL, 32'h1 << 18);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check("R9 stopped inverted high", {31'b0, pwm_o}, 32'h1);
      @(negedge clk);
    end
  endtask

  task automatic t_extremes();
    soft_reset();
    bus_write(A_PER, 4);
    bus_write(A_SAMP, 0);
    bus_write(A_SAMP, 9);
    bus_write(A_CTRL, 32'h1);
    check_wave("R4 zero then full duty", 1, 4, 0, 3, '{0,9,9,9,9,9,9,9});
  endtask

  task automatic t_fields();
    soft_reset();
    bus_write(A_CTRL, 32'h83C3_0056);
    expect_reg("R10 stored fields", A_CTRL, 32'h03C3_0050);
    soft_reset();
    bus_write(A_PER, 6);
    bus_write(A_SAMP, 3);
    bus_write(A_CTRL, 32'h03C3_0001);
    check_wave("R10 fields no effect", 1, 6, 0, 2, '{3,3,3,3,3,3,3,3});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_prescale();
    t_fifo_order();
    t_full_drop();
    t_collision();
    t_soft_reset();
    t_invert();
    t_extremes();
    t_fields();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule